// File: doc/BRIEF.md
# Dual-Write Secure Gate Clear Sequencer

This block lets software clear one semaphore gate, or every gate, without a system reset. A processor must make two writes in a row to a 16-bit clear register. The first write carries an arming key in its upper byte. The second carries the bitwise complement of that key in its upper byte and a gate selector in its lower byte. Both writes must come from the same processor.

Each write arrives with the ID of the processor that issued it. The sequencer tracks the pattern. When the pattern completes, it emits a single-cycle clear pulse together with a gate mask. The gate storage uses this mask to release gates. The notification logic uses the same mask to return each cleared gate's notification state to idle. Any write that does not fit the pattern abandons the sequence without a clear.

A status view shows how far the sequence has progressed and which processor armed it. Bus decoding, gate storage and notification logic are outside this block.

Top module: `gate_clear_seq`

## Requirements
- R1: After reset, `stat_state` is 0 (idle), `stat_pid` is 0, `clr_pulse` is 0 and `clr_mask` is 0.
- R2: In idle, a write whose bits [15:8] equal 0xE2 moves `stat_state` to 1 (armed) on the next cycle and records the writer's ID in `stat_pid`; bits [7:0] of that write are ignored.
- R3: While armed, a write whose bits [15:8] equal 0x1D from the recorded processor raises `clr_pulse` on the next cycle for exactly one cycle, with `stat_state` equal to 2 (firing) during the pulse and 0 on the cycle after.
- R4: When bits [7:0] of the completing write hold a value n from 0 to 15, `clr_mask` during the pulse has only bit n set.
- R5: When bits [7:0] of the completing write hold 16 or more, `clr_mask` during the pulse is 0xFFFF.
- R6: While armed, a write whose upper byte is neither 0x1D nor 0xE2 returns the sequencer to idle with no pulse.
- R7: While armed, a 0x1D write from a processor ID other than the recorded one returns the sequencer to idle with no pulse.
- R8: While armed, a second 0xE2 write returns the sequencer to idle with no pulse; a 0xE2 write after that re-arms it.
- R9: Cycles without a write leave the armed state and the recorded ID unchanged.
- R10: `clr_mask` is 0 on every cycle on which `clr_pulse` is 0; the one mask serves both the gate clear and the notification reset.
- R11: A 0x1D write while idle leaves the sequencer idle and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the clear register |
| wr_data | input | 16 | Write data: key in [15:8], gate selector in [7:0] |
| wr_pid | input | PIDW (1) | ID of the writing processor |
| clr_pulse | output | 1 | One-cycle clear strobe |
| clr_mask | output | GATES (16) | Gates to clear, and notification states to force idle |
| stat_state | output | 2 | Sequence state: 0 idle, 1 armed, 2 firing |
| stat_pid | output | PIDW (1) | ID of the processor that last armed the sequence |

## Verification
The bench targets the ways the sequence should break:
- A complement key from the other processor. A design that skipped the ID compare would clear gates on behalf of a processor that never armed it.
- A repeated arming key. A design that re-armed here would let a second 0xE2 stand in for the first.
- A complement key with nothing armed. A design that ignored the state would fire on half a sequence.

It also checks the selector edge at 15 and 16, where an off-by-one compare turns a single-gate clear into a clear of all gates. Finally, it checks that idle cycles between the two writes do not disarm the sequence, and that the mask is zero outside the pulse.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_FIRE  = 2'd2
  } seq_e;
endpackage

// File: rtl/gcs_key_decode.sv
module gcs_key_decode #(
  parameter int DW   = 16,
  parameter int KW   = 8,
  parameter logic [KW-1:0] KEY1 = 8'hE2
) (
  input  logic [DW-1:0]    data,
  output logic             is_arm,
  output logic             is_fire,
  output logic [DW-KW-1:0] sel
);
  localparam logic [KW-1:0] KEY2 = ~KEY1;
  logic [KW-1:0] key;

  always_comb begin
    key     = data[DW-1:DW-KW];
    sel     = data[DW-KW-1:0];
    is_arm  = (key == KEY1);
    is_fire = (key == KEY2);
  end
endmodule

// File: rtl/gcs_mask_gen.sv
module gcs_mask_gen #(
  parameter int GATES = 16,
  parameter int SELW  = 8
) (
  input  logic [SELW-1:0]  sel,
  output logic [GATES-1:0] mask
);
  localparam logic [SELW-1:0] GLIM = SELW'(GATES);
  logic all_g;

  assign all_g = (sel >= GLIM);

  for (genvar i = 0; i < GATES; i++) begin : g_bit
    assign mask[i] = all_g | (sel == SELW'(i));
  end
endmodule

// File: rtl/gcs_ctrl.sv
module gcs_ctrl
  import gcs_pkg::*;
#(
  parameter int GATES = 16,
  parameter int PIDW  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIDW-1:0]  wr_pid,
  input  logic             is_arm,
  input  logic             is_fire,
  input  logic [GATES-1:0] sel_mask,
  output seq_e             st_q,
  output logic [PIDW-1:0]  pid_q,
  output logic [GATES-1:0] mask_q
);
  seq_e             st_d;
  logic [PIDW-1:0]  pid_d;
  logic [GATES-1:0] mask_d;
  logic             ld_en;

  always_comb begin
    st_d   = SEQ_IDLE;
    pid_d  = pid_q;
    mask_d = '0;
    unique case (st_q)
      SEQ_ARMED: begin
        if (!wr_en) begin
          st_d = SEQ_ARMED;
        end else if (is_fire && (wr_pid == pid_q)) begin
          st_d   = SEQ_FIRE;
          mask_d = sel_mask;
        end
      end
      default: begin
        if (wr_en && is_arm) begin
          st_d  = SEQ_ARMED;
          pid_d = wr_pid;
        end
      end
    endcase
  end

  assign ld_en = wr_en | (st_q == SEQ_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pid_q  <= '0;
      mask_q <= '0;
    end else if (ld_en) begin
      st_q   <= st_d;
      pid_q  <= pid_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/gate_clear_seq.sv
module gate_clear_seq
  import gcs_pkg::*;
#(
  parameter int GATES = 16,
  parameter int PIDW  = 1,
  parameter int DW    = 16,
  parameter int KW    = 8,
  parameter logic [KW-1:0] KEY1 = 8'hE2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [PIDW-1:0]  wr_pid,
  output logic             clr_pulse,
  output logic [GATES-1:0] clr_mask,
  output logic [1:0]       stat_state,
  output logic [PIDW-1:0]  stat_pid
);
  localparam int SELW = DW - KW;

  logic            is_arm, is_fire;
  logic [SELW-1:0] sel;
  logic [GATES-1:0] sel_mask;
  seq_e            st_q;

  gcs_key_decode #(.DW(DW), .KW(KW), .KEY1(KEY1)) u_dec (
    .data(wr_data), .is_arm(is_arm), .is_fire(is_fire), .sel(sel)
  );

  gcs_mask_gen #(.GATES(GATES), .SELW(SELW)) u_mask (
    .sel(sel), .mask(sel_mask)
  );

  gcs_ctrl #(.GATES(GATES), .PIDW(PIDW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pid(wr_pid),
    .is_arm(is_arm), .is_fire(is_fire), .sel_mask(sel_mask),
    .st_q(st_q), .pid_q(stat_pid), .mask_q(clr_mask)
  );

  assign stat_state = st_q;
  assign clr_pulse  = (st_q == SEQ_FIRE);
endmodule

// File: rtl/gate_clear_seq_chk.sv
module gate_clear_seq_chk #(
  parameter int GATES = 16,
  parameter int PIDW  = 1,
  parameter int DW    = 16,
  parameter int KW    = 8,
  parameter logic [KW-1:0] KEY1 = 8'hE2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DW-1:0]    wr_data,
  input logic [PIDW-1:0]  wr_pid,
  input logic             clr_pulse,
  input logic [GATES-1:0] clr_mask,
  input logic [1:0]       stat_state,
  input logic [PIDW-1:0]  stat_pid
);
  localparam logic [KW-1:0] KEY2 = ~KEY1;

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);

  a_r3_r7_fire_source: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $past(stat_state == 2'd1 && wr_en &&
                        wr_data[DW-1:DW-KW] == KEY2 && wr_pid == stat_pid));

  a_r4_r5_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> ($onehot(clr_mask) || (&clr_mask)));

  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |-> (clr_mask == '0));

  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state != 2'd1 && wr_en && wr_data[DW-1:DW-KW] == KEY1)
      |=> (stat_state == 2'd1 && stat_pid == $past(wr_pid)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == 2'd1 && !wr_en) |=> (stat_state == 2'd1 && $stable(stat_pid)));

  a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state != 2'd3);
endmodule

bind gate_clear_seq gate_clear_seq_chk #(
  .GATES(GATES), .PIDW(PIDW), .DW(DW), .KW(KW), .KEY1(KEY1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .wr_pid(wr_pid), .clr_pulse(clr_pulse), .clr_mask(clr_mask),
  .stat_state(stat_state), .stat_pid(stat_pid)
);

// File: tb/sim_gate_clear_seq.sv
module sim_gate_clear_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [0:0]  wr_pid = '0;
  logic        clr_pulse;
  logic [15:0] clr_mask;
  logic [1:0]  stat_state;
  logic [0:0]  stat_pid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gate_clear_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_pid(wr_pid), .clr_pulse(clr_pulse), .clr_mask(clr_mask),
    .stat_state(stat_state), .stat_pid(stat_pid)
  );

  // {first data, first pid, second data, second pid, pulse expected, mask expected}
  localparam logic [50:0] VEC [0:7] = '{
    {16'hE200, 1'b0, 16'h1D03, 1'b0, 1'b1, 16'h0008},  // R4
    {16'hE2FF, 1'b1, 16'h1D0F, 1'b1, 1'b1, 16'h8000},  // R4 edge, R2 low byte ignored
    {16'hE200, 1'b0, 16'h1D10, 1'b0, 1'b1, 16'hFFFF},  // R5 edge
    {16'hE255, 1'b1, 16'h1DFF, 1'b1, 1'b1, 16'hFFFF},  // R5
    {16'hE200, 1'b0, 16'h1C03, 1'b0, 1'b0, 16'h0000},  // R6
    {16'hE200, 1'b0, 16'h1D03, 1'b1, 1'b0, 16'h0000},  // R7
    {16'hE200, 1'b0, 16'hE203, 1'b0, 1'b0, 16'h0000},  // R8
    {16'hE200, 1'b1, 16'h1D00, 1'b1, 1'b1, 16'h0001}   // R4 gate 0
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // drive on a falling edge; after the call the capturing edge has passed
  task automatic wr(input logic [15:0] d, input logic [0:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_pid = p;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle_ok(input string rq);
    chk(stat_state == 2'd0 && !clr_pulse, rq, {30'd0, stat_state}, 32'd0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat_state == 2'd0 && stat_pid == 1'b0 && !clr_pulse && clr_mask == 16'h0,
        "R1 reset", {13'd0, stat_state, stat_pid, clr_pulse, clr_mask}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_state == 2'd0 && clr_mask == 16'h0, "R1 after release",
        {14'd0, stat_state, clr_mask}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][50:35], VEC[i][34]);
      chk(stat_state == 2'd1 && stat_pid == VEC[i][34], "R2 armed",
          {29'd0, stat_state, stat_pid}, {29'd0, 2'd1, VEC[i][34]});
      wr(VEC[i][33:18], VEC[i][17]);
      chk(clr_pulse == VEC[i][16] && clr_mask == VEC[i][15:0], "R4 R5 R6 R7 R8 vector",
          {15'd0, clr_pulse, clr_mask}, {15'd0, VEC[i][16], VEC[i][15:0]});
      if (VEC[i][16])
        chk(stat_state == 2'd2, "R3 firing state", {30'd0, stat_state}, 32'd2);
      @(negedge clk);
      idle_ok("R3 R6 R7 R8 back to idle");
      chk(clr_mask == 16'h0, "R10 mask quiet", {16'd0, clr_mask}, 32'd0);
    end

    // R8: repeated key abandons, a later key re-arms
    wr(16'hE200, 1'b1);
    wr(16'hE200, 1'b1);
    idle_ok("R8 second key abandons");
    wr(16'hE200, 1'b0);
    chk(stat_state == 2'd1 && stat_pid == 1'b0, "R8 re-arm",
        {30'd0, stat_state}, 32'd1);
    wr(16'h1D05, 1'b0);
    chk(clr_pulse && clr_mask == 16'h0020, "R8 re-armed fire",
        {15'd0, clr_pulse, clr_mask}, {15'd0, 1'b1, 16'h0020});

    // R9: idle cycles between the writes
    wr(16'hE200, 1'b1);
    repeat (6) @(negedge clk);
    chk(stat_state == 2'd1 && stat_pid == 1'b1, "R9 hold armed",
        {29'd0, stat_state, stat_pid}, {29'd0, 2'd1, 1'b1});
    wr(16'h1D0E, 1'b1);
    chk(clr_pulse && clr_mask == 16'h4000, "R9 late fire",
        {15'd0, clr_pulse, clr_mask}, {15'd0, 1'b1, 16'h4000});
    @(negedge clk);
    chk(!clr_pulse, "R3 single cycle", {31'd0, clr_pulse}, 32'd0);

    // R11: complement key with nothing armed
    wr(16'h1D03, 1'b0);
    idle_ok("R11 idle complement key");
    chk(clr_mask == 16'h0, "R11 no mask", {16'd0, clr_mask}, 32'd0);

    // R1: reset mid-sequence
    wr(16'hE200, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(stat_state == 2'd0 && stat_pid == 1'b0, "R1 reset while armed",
        {29'd0, stat_state, stat_pid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule